// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns the memory requests of an 8-bit controller core into cycles on a multiplexed external bus. It runs on the oscillator clock, one clock per oscillator period. A machine cycle is twelve clocks long, and each machine cycle carries one request. The request can be idle, a code fetch, a data read or a data write.

The low port carries the low address byte first and then data. The high port carries the high address byte, or the contents of a port latch register for 8-bit addressed data accesses. An address strobe (`ale`) goes out twice per machine cycle while the core runs idle or fetches code. Each code-fetch machine cycle reads two consecutive bytes, each under its own program-store strobe. A data machine cycle suppresses the second address strobe and both program-store strobes. Instead it gives one long read or write strobe.

The core presents its next request while `mc_last` is high, and the block samples it at the end of that clock. Read bytes appear on `rdata` with a one-clock `rvalid` pulse. The low port is open-drain whenever the bus does not own it.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst_n` is low, `ale` is 0 and `psen_n`, `rd_n` and `wr_n` are 1. `rvalid` is 0 and `rdata` is 0. After release, the sequencer is at position 0 of an idle machine cycle.
- R2: Positions 0 to 11 of a machine cycle count one per clock. In idle and fetch machine cycles, `ale` is high at positions 0, 1, 6 and 7 and low at all others.
- R3: In a fetch machine cycle, `psen_n` is low at positions 3 to 5 and 9 to 11. That gives two program-store strobes of three clocks each.
- R4: In a read or write machine cycle, `ale` is high only at positions 0 and 1, and `psen_n` stays high.
- R5: In a fetch machine cycle, the low port drives the low address byte with all enables set at positions 0 to 2 and 6 to 8. In a data machine cycle, it does so at positions 0 to 2.
- R6: The second half of a fetch machine cycle (positions 6 to 11) addresses the request address plus one, with 16-bit wrap-around. This applies to both ports.
- R7: The high port carries the high byte of the addressed byte during fetches and during data accesses with `req_a16`=1. In all other cases it carries `p2_latch`.
- R8: In a read machine cycle, all low-port enables are 0 from position 3 onward. `rd_n` is low at positions 4 to 9. `p0_in` is sampled at the clock edge that ends position 9.
- R9: In a write machine cycle, the low port drives `req_wdata` at positions 3 to 10 and floats at position 11. `wr_n` is low at positions 4 to 9.
- R10: A fetch samples `p0_in` at the edges ending positions 5 and 11. After every sample, `rvalid` is high for exactly the next clock, and `rdata` holds the sampled byte until the next sample.
- R11: In an idle machine cycle, `p0_out` is 0 and each bit of `p0_oe` is the inverse of the matching `p0_latch` bit. A latch 1 therefore floats and a latch 0 is driven low.
- R12: `mc_last` is high exactly at position 11. Request inputs are sampled only at the edge ending that position. The codes are: 0 idle, 1 fetch, 2 read, 3 write.
- R13: `rd_n` and `wr_n` are never low together, and neither is ever low while `psen_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cmd | input | 2 | Request for the next machine cycle: 0 idle, 1 fetch, 2 read, 3 write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_a16 | input | 1 | 1: 16-bit data address, 0: 8-bit data address |
| p2_latch | input | 8 | High port latch contents |
| p0_latch | input | 8 | Low port latch contents |
| p0_in | input | 8 | Low port pin values |
| p0_out | output | 8 | Low port output values |
| p0_oe | output | 8 | Low port per-bit output enables |
| p2_out | output | 8 | High port output values |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| mc_last | output | 1 | Last clock of the machine cycle; request inputs are sampled at its end |
| rdata | output | 8 | Last captured byte |
| rvalid | output | 1 | One-clock pulse after each capture |

## Verification
At the edge that ends position 11, the second fetched byte is captured while the next request is latched. On a fetch, both actions happen on the same edge. The bench queues a fetch followed directly by a read, a write and another fetch to provoke this. It checks that `rdata` holds the old machine cycle's byte while the new cycle's address already appears on the ports. Between sampling edges, the bench drives changing junk on the request inputs. Its behavioural model, compared on every clock, shows that only the value present during `mc_last` takes effect.

// File: rtl/ebs_pkg.sv
// Shared types and machine-cycle timing positions for the external bus sequencer.
// Assumes one clock per oscillator period and a twelve-position machine cycle.
package ebs_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_FETCH = 2'd1,
        CMD_READ  = 2'd2,
        CMD_WRITE = 2'd3
    } bus_cmd_e;

    localparam int unsigned POS_W = 4;
    localparam logic [POS_W-1:0] MC_LEN_M1   = 4'd11; // last position of a machine cycle
    localparam logic [POS_W-1:0] HALF_LEN    = 4'd6;  // positions per fetch half
    localparam logic [POS_W-1:0] ALE_LAST    = 4'd1;  // ale high up to here in a half
    localparam logic [POS_W-1:0] ADDR_LAST   = 4'd2;  // address held up to here
    localparam logic [POS_W-1:0] PSEN_FIRST  = 4'd3;  // program strobe starts here in a half
    localparam logic [POS_W-1:0] HALF_LAST   = 4'd5;  // fetch byte sampled at end of this
    localparam logic [POS_W-1:0] STB_FIRST   = 4'd4;  // data strobe first position
    localparam logic [POS_W-1:0] STB_LAST    = 4'd9;  // data strobe last position
    localparam logic [POS_W-1:0] WDATA_LAST  = 4'd10; // write data held up to here

endpackage

// File: rtl/ebs_phase_ctr.sv
// Machine-cycle position counter: counts 0..11 once per clock and flags the last position.
// Assumes a synchronous active-low reset that returns the counter to position 0.
module ebs_phase_ctr
    import ebs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos,
    output logic             last
);

    // Advance the position and wrap after the last position of the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (pos == MC_LEN_M1) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // Flag the clock whose closing edge samples the next request.
    always_comb begin
        last = (pos == MC_LEN_M1);
    end

endmodule

// File: rtl/ebs_req_latch.sv
// Request register: holds command, address, write data and addressing mode for one machine cycle.
// Assumes the caller asserts take only at the last position of a machine cycle.
module ebs_req_latch
    import ebs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  bus_cmd_e          in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_a16,
    output bus_cmd_e          cur_cmd,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_a16
);

    // Capture the request at the machine-cycle boundary, idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cmd   <= CMD_IDLE;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_a16   <= 1'b0;
        end else if (take) begin
            cur_cmd   <= in_cmd;
            cur_addr  <= in_addr;
            cur_wdata <= in_wdata;
            cur_a16   <= in_a16;
        end
    end

endmodule

// File: rtl/ebs_pin_decode.sv
// Pin decoder: derives strobes, port drives and the capture request from position and request.
// Assumes ADDR_W equals twice DATA_W; outputs are decoded from registered state only.
module ebs_pin_decode
    import ebs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos,
    input  bus_cmd_e          cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              a16,
    input  logic [DATA_W-1:0] p0_latch,
    input  logic [DATA_W-1:0] p2_latch,
    output logic [DATA_W-1:0] p0_out,
    output logic [DATA_W-1:0] p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              cap_now
);

    localparam logic [DATA_W-1:0] ALL_ON  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ALL_OFF = {DATA_W{1'b0}};

    logic              second_half;
    logic [POS_W-1:0]  sub;
    logic [ADDR_W-1:0] byte_addr;
    logic [DATA_W-1:0] port_oe;
    logic              in_stb;

    // Open-drain port mode: each bit drives low only where its latch holds 0.
    for (genvar b = 0; b < DATA_W; b++) begin : g_od
        assign port_oe[b] = ~p0_latch[b];
    end

    // Split the position into fetch half and position inside the half.
    always_comb begin
        second_half = (pos >= HALF_LEN);
        sub         = second_half ? (pos - HALF_LEN) : pos;
        byte_addr   = addr + ADDR_W'(second_half && (cmd == CMD_FETCH));
        in_stb      = (pos >= STB_FIRST) && (pos <= STB_LAST);
    end

    // Decode every pin for the current position and request kind.
    always_comb begin
        ale     = 1'b0;
        psen_n  = 1'b1;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        cap_now = 1'b0;
        p0_out  = ALL_OFF;
        p0_oe   = ALL_OFF;
        p2_out  = p2_latch;
        unique case (cmd)
            CMD_IDLE: begin
                ale   = (sub <= ALE_LAST);
                p0_oe = port_oe;
            end
            CMD_FETCH: begin
                ale    = (sub <= ALE_LAST);
                psen_n = !(sub >= PSEN_FIRST);
                p2_out = byte_addr[ADDR_W-1 -: DATA_W];
                if (sub <= ADDR_LAST) begin
                    p0_out = byte_addr[DATA_W-1:0];
                    p0_oe  = ALL_ON;
                end
                cap_now = (sub == HALF_LAST);
            end
            CMD_READ: begin
                ale  = (pos <= ALE_LAST);
                rd_n = !in_stb;
                if (a16) p2_out = addr[ADDR_W-1 -: DATA_W];
                if (pos <= ADDR_LAST) begin
                    p0_out = addr[DATA_W-1:0];
                    p0_oe  = ALL_ON;
                end
                cap_now = (pos == STB_LAST);
            end
            CMD_WRITE: begin
                ale  = (pos <= ALE_LAST);
                wr_n = !in_stb;
                if (a16) p2_out = addr[ADDR_W-1 -: DATA_W];
                if (pos <= ADDR_LAST) begin
                    p0_out = addr[DATA_W-1:0];
                    p0_oe  = ALL_ON;
                end else if (pos <= WDATA_LAST) begin
                    p0_out = wdata;
                    p0_oe  = ALL_ON;
                end
            end
            default: ;
        endcase
        if (!rst_n) begin
            ale     = 1'b0;
            psen_n  = 1'b1;
            rd_n    = 1'b1;
            wr_n    = 1'b1;
            cap_now = 1'b0;
        end
    end

endmodule

// File: rtl/ebs_rd_capture.sv
// Read capture: samples the low port when requested and pulses valid for one clock.
// Assumes cap_now is high only during the last clock of a read or program strobe.
module ebs_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_now,
    input  logic [DATA_W-1:0] pin,
    output logic [DATA_W-1:0] data,
    output logic              valid
);

    // Hold the last sampled byte and flag the clock that follows each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= cap_now;
            if (cap_now) data <= pin;
        end
    end

endmodule

// File: rtl/ext_bus_seq.sv
// External bus sequencer top: one request per twelve-clock machine cycle on a multiplexed bus.
// Assumes the core presents its request while mc_last is high; ADDR_W = 2 * DATA_W.
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_a16,
    input  logic [DATA_W-1:0] p2_latch,
    input  logic [DATA_W-1:0] p0_latch,
    input  logic [DATA_W-1:0] p0_in,
    output logic [DATA_W-1:0] p0_out,
    output logic [DATA_W-1:0] p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mc_last,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [POS_W-1:0]  pos;
    bus_cmd_e          cur_cmd;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_a16;
    logic              cap_now;

    ebs_phase_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (pos),
        .last  (mc_last)
    );

    ebs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (mc_last),
        .in_cmd    (bus_cmd_e'(req_cmd)),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .in_a16    (req_a16),
        .cur_cmd   (cur_cmd),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_a16   (cur_a16)
    );

    ebs_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .rst_n    (rst_n),
        .pos      (pos),
        .cmd      (cur_cmd),
        .addr     (cur_addr),
        .wdata    (cur_wdata),
        .a16      (cur_a16),
        .p0_latch (p0_latch),
        .p2_latch (p2_latch),
        .p0_out   (p0_out),
        .p0_oe    (p0_oe),
        .p2_out   (p2_out),
        .ale      (ale),
        .psen_n   (psen_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .cap_now  (cap_now)
    );

    ebs_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_now (cap_now),
        .pin     (p0_in),
        .data    (rdata),
        .valid   (rvalid)
    );

endmodule

// File: rtl/ext_bus_seq_chk.sv
// Protocol checker for the external bus sequencer, attached to every instance by bind.
// Assumes the same synchronous active-low reset as the design.
module ext_bus_seq_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic              psen_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [DATA_W-1:0] p0_oe,
    input logic              mc_last,
    input logic              rvalid
);

    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n) && !(!psen_n && (!rd_n || !wr_n)));

    p_read_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (p0_oe == '0));

    p_write_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (p0_oe == '1));

    p_ale_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale ##1 !ale);

    p_psen_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |=> !psen_n ##1 !psen_n);

    p_last_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mc_last |=> !mc_last);

    p_valid_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(!psen_n || !rd_n));

endmodule

bind ext_bus_seq ext_bus_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .p0_oe   (p0_oe),
    .mc_last (mc_last),
    .rvalid  (rvalid)
);

// File: tb/ext_bus_seq_bench.sv
// Bench for the external bus sequencer: a behavioural per-clock model compared on every clock.
module ext_bus_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_cmd = '0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_a16 = 1'b0;
    logic [7:0] p2_latch = 8'h3C;
    logic [7:0] p0_latch = 8'hA5;
    logic [7:0] p0_in = '0;
    logic [7:0] p0_out, p0_oe, p2_out, rdata;
    logic       ale, psen_n, rd_n, wr_n, mc_last, rvalid;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // model state
    int m_pos = 0, m_cmd = 0, m_addr = 0, m_wd = 0, m_a16 = 0;
    int m_rdata = 0, m_rvalid = 0;

    int q_cmd[$], q_addr[$], q_wd[$], q_a16[$];

    always #10 clk = ~clk;

    ext_bus_seq u_ext_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_a16(req_a16), .p2_latch(p2_latch),
        .p0_latch(p0_latch), .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
        .p2_out(p2_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .mc_last(mc_last), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s pos=%0d cmd=%0d actual=%0h expected=%0h",
                     tag, what, m_pos, m_cmd, act, exp);
        end
    endtask

    task automatic push(input int c, input int a, input int w, input int s);
        q_cmd.push_back(c); q_addr.push_back(a); q_wd.push_back(w); q_a16.push_back(s);
    endtask

    // Compare every output against the model for the current clock.
    task automatic compare_all();
        int sub, ba, e_ale, e_psen, e_rd, e_wr, e_oe, e_out, e_p2;
        string t_ale, t_port, t_p2;
        sub = m_pos % 6;
        ba = m_addr;
        if (m_cmd == 1 && m_pos >= 6) ba = (m_addr + 1) & 16'hFFFF;
        e_psen = 1; e_rd = 1; e_wr = 1; e_oe = 0; e_out = 0; e_p2 = p2_latch;
        t_ale = "R2"; t_port = "R11"; t_p2 = "R7";
        if (m_cmd == 2 || m_cmd == 3) begin
            e_ale = (m_pos < 2); t_ale = "R4";
        end else e_ale = (sub < 2);
        case (m_cmd)
            0: begin e_oe = (~p0_latch) & 8'hFF; end
            1: begin
                e_psen = (sub >= 3) ? 0 : 1;
                e_p2 = ba >> 8;
                if (sub < 3) begin e_oe = 8'hFF; e_out = ba & 8'hFF; end
                t_port = (m_pos >= 6) ? "R6" : "R5";
                if (m_pos >= 6) t_p2 = "R6";
            end
            2: begin
                if (m_a16 != 0) e_p2 = m_addr >> 8;
                e_rd = (m_pos >= 4 && m_pos <= 9) ? 0 : 1;
                if (m_pos < 3) begin e_oe = 8'hFF; e_out = m_addr & 8'hFF; t_port = "R5"; end
                else t_port = "R8";
            end
            default: begin
                if (m_a16 != 0) e_p2 = m_addr >> 8;
                e_wr = (m_pos >= 4 && m_pos <= 9) ? 0 : 1;
                if (m_pos < 3) begin e_oe = 8'hFF; e_out = m_addr & 8'hFF; t_port = "R5"; end
                else if (m_pos <= 10) begin e_oe = 8'hFF; e_out = m_wd; t_port = "R9"; end
                else t_port = "R9";
            end
        endcase
        if (!rst_n) begin
            e_ale = 0; e_psen = 1; e_rd = 1; e_wr = 1;
            t_ale = "R1";
            check("R1", "rvalid in reset", int'(rvalid), 0);
            check("R1", "rdata in reset", int'(rdata), 0);
        end
        check(t_ale, "ale", int'(ale), e_ale);
        check(m_cmd == 2 || m_cmd == 3 ? "R4" : "R3", "psen_n", int'(psen_n), e_psen);
        check("R8", "rd_n", int'(rd_n), e_rd);
        check("R9", "wr_n", int'(wr_n), e_wr);
        check(t_port, "p0_oe", int'(p0_oe), e_oe);
        check(t_port, "p0_out", int'(p0_out), e_out);
        check(t_p2, "p2_out", int'(p2_out), e_p2);
        check("R12", "mc_last", int'(mc_last), (m_pos == 11) ? 1 : 0);
        check("R10", "rvalid", int'(rvalid), m_rvalid);
        check("R10", "rdata", int'(rdata), m_rdata);
        check("R13", "strobe overlap", int'((!rd_n && !wr_n) || (!psen_n && (!rd_n || !wr_n))), 0);
    endtask

    // Advance the model by one clock edge using the values the bench is driving.
    task automatic model_step();
        int cap;
        if (!rst_n) begin
            m_pos = 0; m_cmd = 0; m_addr = 0; m_wd = 0; m_a16 = 0;
            m_rdata = 0; m_rvalid = 0;
            return;
        end
        cap = ((m_cmd == 1) && (m_pos % 6 == 5)) || ((m_cmd == 2) && (m_pos == 9));
        m_rvalid = cap;
        if (cap != 0) m_rdata = p0_in;
        if (m_pos == 11) begin
            m_cmd = req_cmd; m_addr = req_addr; m_wd = req_wdata; m_a16 = req_a16;
        end
        m_pos = (m_pos + 1) % 12;
    endtask

    initial begin : main
        int tail;
        push(0, 16'h0000, 0, 0);
        push(1, 16'h1234, 0, 0);       // R3 R5 R6 fetch
        push(1, 16'hFFFF, 0, 0);       // R6 wrap
        push(2, 16'hABCD, 0, 1);       // R8 R7 16-bit read
        push(2, 16'h9942, 0, 0);       // R7 8-bit read uses latch
        push(3, 16'h8001, 8'h5A, 1);   // R9 write
        push(3, 16'h4477, 8'hFF, 0);   // R9 8-bit write
        push(0, 16'h0000, 0, 0);       // R11 idle
        push(1, 16'h2000, 0, 0);       // fetch then data back to back
        push(2, 16'h3010, 0, 1);
        push(1, 16'h00FF, 0, 0);
        push(3, 16'h5566, 8'h00, 1);
        push(1, 16'h7FFE, 0, 0);
        push(0, 16'h0000, 0, 0);
        tail = 30;
        for (int n = 0; n < 100000; n++) begin
            @(negedge clk);
            compare_all();
            rst_n = (n >= 4);
            p0_in = 8'((n * 29 + 7) & 8'hFF);
            if (n % 5 == 0) p2_latch = 8'((n * 13 + 1) & 8'hFF);
            if (n % 7 == 0) p0_latch = 8'((n * 53 + 9) & 8'hFF);
            if (rst_n && m_pos == 11 && q_cmd.size() > 0) begin
                req_cmd = 2'(q_cmd.pop_front());
                req_addr = 16'(q_addr.pop_front());
                req_wdata = 8'(q_wd.pop_front());
                req_a16 = 1'(q_a16.pop_front());
            end else if (rst_n && m_pos == 11) begin
                req_cmd = 2'd0;
                tail--;
            end else begin
                // junk between sampling edges: must have no effect (R12)
                req_cmd = 2'(n % 4);
                req_addr = 16'((n * 97) & 16'hFFFF);
                req_wdata = 8'((n * 11) & 8'hFF);
                req_a16 = 1'(n % 2);
            end
            @(posedge clk);
            model_step();
            if (q_cmd.size() == 0 && tail <= 0) break;
            if (q_cmd.size() == 0 && m_pos == 0 && tail > 2) tail = 2;
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule